// File: doc/BRIEF.md
# Serial Debug Read Sequencer

This block is the target end of a synchronous serial debug port. A host drives a serial clock and exchanges 17-bit frames with the block in both directions at once. Each frame is shifted in on the host data line while the reply to the frame before it is shifted out on the return line. A reply therefore always describes the frame that came before, so command issue and result return overlap.

The block decodes a command word. For a memory read it takes the upper and then the lower half of a 32-bit address from the next two frames. It then raises one request on a simple request/acknowledge memory bus and holds it until the acknowledge arrives. Until the result is available the host polls and gets a not-ready status. The result then returns over two frames, upper half first. The lower half travels with the next command frame. A bus error, an unknown command and a no-operation command each produce their own status reply.

Bit 16 of a reply is a status flag. When the flag is 0, the low 16 bits are data, except that 0xFFFF with the flag clear means command complete. When the flag is 1, the low bits carry a status: 0x0000 is not ready, 0x0001 is bus error and 0xFFFF is illegal command.

States: `ST_IDLE` decodes a command. `ST_SKIP` drops the frame after an illegal command. `ST_ADDR_HI` and `ST_ADDR_LO` collect the address. `ST_BUSY` holds the memory request. `ST_DONE` holds the captured result. `ST_RES_LO` sends the lower result half.

Transitions, each taken at the end of a frame unless noted:
- IDLE→ADDR_HI on a read command.
- IDLE→IDLE on a no-op.
- IDLE→SKIP on any other word.
- SKIP→IDLE.
- ADDR_HI→ADDR_LO.
- ADDR_LO→BUSY.
- BUSY→DONE on the acknowledge, at any clock.
- DONE→RES_LO on success.
- DONE→IDLE on a bus error.
- RES_LO→IDLE.

Top module: `dbg_cmd_seq`

## Requirements
- R1: A frame is 17 bits, shifted MSB first on rising edges of the serial clock after a two-stage synchronizer. Each serial clock phase lasts at least 4 processor clocks. The reply shifted out during a frame is the one produced by the frame before it.
- R2: After reset the memory request is low, the return line is high, and the first frame returns not-ready (0x1_0000).
- R3: A frame equal to 0x0_1900 in idle is a read command and gets a not-ready reply. The next two frames give address bits 31:16 and then 15:0, and each gets a not-ready reply. The memory request rises after the third frame, with the address formed from the two halves.
- R4: Every frame that completes while the memory request is outstanding gets a not-ready reply.
- R5: After a successful access, the next frame to complete returns {0, data[31:16]}. The frame after that returns {0, data[15:0]}, and the frame following it is decoded as a command.
- R6: After an access that ends in a bus error, the next frame to complete returns 0x1_0001. The following frame is decoded as a command.
- R7: A frame equal to 0x0_0000 in idle is a no-op: it returns command complete (0x0_FFFF) and the block stays idle.
- R8: Any other frame in idle, including one with bit 16 set, returns illegal (0x1_FFFF) and raises no memory request. The frame after it is discarded with a not-ready reply, and the block is then idle again.
- R9: A new frame may start as soon as the serial clock has gone low after the 17th rising edge, well inside 32 processor clocks.
- R10: The memory request and address stay stable until the acknowledge, and the request drops on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_sclk | input | 1 | Host serial clock, asynchronous to clk |
| dbg_sdi | input | 1 | Serial data from the host, MSB first |
| dbg_sdo | output | 1 | Serial reply to the host, MSB first |
| mem_req | output | 1 | Memory read request, held until acknowledge |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | One-cycle completion strobe |
| mem_err | input | 1 | Bus error, qualified by mem_ack |
| mem_rdata | input | 32 | Read data, qualified by mem_ack |

## Verification
The bench builds the block with its default parameters: read code 0x1900, no-op code 0x0000, and a two-stage synchronizer. With these, 4-clock serial phases and back-to-back frames with no idle gap exercise the tightest handover between a reply load and the next first bit. The bench drives the acknowledge both between frames and in the middle of a poll frame, so both paths into the result-return sequence are covered. Illegal words with and without bit 16 set reach the discard path, and a no-op frame then shows that the block is idle again.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int WORD_W  = 16;
    localparam int FRAME_W = WORD_W + 1;
    localparam int ADDR_W  = 2 * WORD_W;

    typedef logic [FRAME_W-1:0] frame_t;

    // bit 16 = status flag; low bits = data or status code
    localparam frame_t REPLY_NOTRDY   = {1'b1, {WORD_W{1'b0}}};
    localparam frame_t REPLY_BUSERR   = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};
    localparam frame_t REPLY_ILLEGAL  = {1'b1, {WORD_W{1'b1}}};
    localparam frame_t REPLY_COMPLETE = {1'b0, {WORD_W{1'b1}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_BUSY,
        ST_DONE,
        ST_RES_LO
    } seq_state_t;

endpackage

// File: rtl/dbg_frame_shifter.sv
module dbg_frame_shifter #(
    parameter int                 FRAME_W     = 17,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [FRAME_W-1:0] RESET_REPLY = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_val,
    output logic               sdo,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [SYNC_STAGES-1:0] sclk_sync;
    logic [SYNC_STAGES-1:0] sdi_sync;
    logic                   sclk_prev;
    logic                   rise;
    logic                   last;
    logic [FRAME_W-1:0]     tx_q;
    logic [FRAME_W-1:0]     rx_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   done_q;

    // synchronizer chains for the host clock and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            sdi_sync  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            sdi_sync  <= {sdi_sync[SYNC_STAGES-2:0], sdi};
            sclk_prev <= sclk_sync[SYNC_STAGES-1];
        end
    end

    assign rise = sclk_sync[SYNC_STAGES-1] & ~sclk_prev;
    assign last = (cnt_q == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= RESET_REPLY;
            rx_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= rise && last;
            if (load_en) begin
                tx_q <= load_val;
            end else if (rise) begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
            if (rise) begin
                rx_q  <= {rx_q[FRAME_W-2:0], sdi_sync[SYNC_STAGES-1]};
                cnt_q <= last ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign sdo        = tx_q[FRAME_W-1];
    assign frame_done = done_q;
    assign frame_word = rx_q;

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] CMD_READ = 16'h1900,
    parameter logic [WORD_W-1:0] CMD_NOP  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  frame_t            frame_word,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              load_en,
    output frame_t            load_val,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output seq_state_t        state_o
);

    seq_state_t        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] res_q;
    logic              err_q;
    logic              is_read;
    logic              is_nop;

    assign is_read = (frame_word == {1'b0, CMD_READ});
    assign is_nop  = (frame_word == {1'b0, CMD_NOP});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (frame_done) begin
                if (is_read)     state_nx = ST_ADDR_HI;
                else if (!is_nop) state_nx = ST_SKIP;
            end
            ST_SKIP:    if (frame_done) state_nx = ST_IDLE;
            ST_ADDR_HI: if (frame_done) state_nx = ST_ADDR_LO;
            ST_ADDR_LO: if (frame_done) state_nx = ST_BUSY;
            ST_BUSY:    if (mem_ack)    state_nx = ST_DONE;
            ST_DONE:    if (frame_done) state_nx = err_q ? ST_IDLE : ST_RES_LO;
            ST_RES_LO:  if (frame_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs: reply chosen by the state the frame completed in
    always_comb begin
        load_en  = frame_done;
        load_val = REPLY_NOTRDY;
        unique case (state)
            ST_IDLE: begin
                if (is_read)     load_val = REPLY_NOTRDY;
                else if (is_nop) load_val = REPLY_COMPLETE;
                else             load_val = REPLY_ILLEGAL;
            end
            ST_DONE:   load_val = err_q ? REPLY_BUSERR
                                        : {1'b0, res_q[ADDR_W-1:WORD_W]};
            ST_RES_LO: load_val = {1'b0, res_q[WORD_W-1:0]};
            default:   load_val = REPLY_NOTRDY;
        endcase
    end

    assign mem_req  = (state == ST_BUSY);
    assign mem_addr = addr_q;
    assign state_o  = state;

    // address and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            res_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (frame_done && state == ST_ADDR_HI)
                addr_q[ADDR_W-1:WORD_W] <= frame_word[WORD_W-1:0];
            if (frame_done && state == ST_ADDR_LO)
                addr_q[WORD_W-1:0] <= frame_word[WORD_W-1:0];
            if (state == ST_BUSY && mem_ack) begin
                res_q <= mem_rdata;
                err_q <= mem_err;
            end
        end
    end

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] CMD_READ    = 16'h1900,
    parameter logic [WORD_W-1:0] CMD_NOP     = 16'h0000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_sclk,
    input  logic              dbg_sdi,
    output logic              dbg_sdo,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [ADDR_W-1:0] mem_rdata
);

    logic       frame_done;
    frame_t     frame_word;
    logic       load_en;
    frame_t     load_val;
    seq_state_t fsm_state;

    dbg_frame_shifter #(
        .FRAME_W     (FRAME_W),
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_REPLY (REPLY_NOTRDY)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (dbg_sclk),
        .sdi        (dbg_sdi),
        .load_en    (load_en),
        .load_val   (load_val),
        .sdo        (dbg_sdo),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    dbg_seq_fsm #(
        .CMD_READ (CMD_READ),
        .CMD_NOP  (CMD_NOP)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .load_en    (load_en),
        .load_val   (load_val),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .state_o    (fsm_state)
    );

endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk
    import dbg_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input frame_t            frame_word,
    input seq_state_t        state,
    input logic              dbg_sdo,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    // R10: request and address held until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R10: request withdrawn after the acknowledge
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    // R4: a frame completing during the access loads a status reply
    p_busy_notready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && state == ST_BUSY && !mem_ack |=> dbg_sdo);

    // R8: flagged word in idle leads to the discard state with a status reply
    p_illegal_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && state == ST_IDLE && frame_word[FRAME_W-1]
        |=> state == ST_SKIP && dbg_sdo);

    // R3: the low-address frame starts the access
    p_addr_starts_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && state == ST_ADDR_LO |=> mem_req);

    // R1: frame completion is a single-cycle event
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .state      (fsm_state),
    .dbg_sdo    (dbg_sdo),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr)
);

// File: tb/tb_dbg_cmd_seq.sv
`timescale 1ns/1ps
module tb_dbg_cmd_seq;

    localparam logic [15:0] RD  = 16'h1900;
    localparam logic [15:0] NOP = 16'h0000;
    localparam logic [16:0] NR  = 17'h1_0000;
    localparam logic [16:0] BE  = 17'h1_0001;
    localparam logic [16:0] ILL = 17'h1_FFFF;
    localparam logic [16:0] CC  = 17'h0_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    logic [16:0] exp_reply;
    int          ms = 0;
    logic [31:0] m_addr, m_data, exp_addr;
    bit          m_acked = 0, m_err = 0, exp_busy = 0;

    always #2 clk = ~clk;

    dbg_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .dbg_sclk(sclk), .dbg_sdi(sdi), .dbg_sdo(sdo),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison of the bus address against the model (R10)
    always @(negedge clk) begin
        cycles++;
        if (rst_n && exp_busy && mem_req) check("R10", mem_addr, exp_addr);
        if (cycles > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic model_step(input logic [16:0] w);
        case (ms)
            0: begin
                if (w == {1'b0, RD})       begin exp_reply = NR; ms = 2; end
                else if (w == {1'b0, NOP}) begin exp_reply = CC; end
                else                       begin exp_reply = ILL; ms = 1; end
            end
            1: begin exp_reply = NR; ms = 0; end
            2: begin m_addr[31:16] = w[15:0]; exp_reply = NR; ms = 3; end
            3: begin
                m_addr[15:0] = w[15:0]; exp_reply = NR; ms = 4;
                exp_addr = m_addr; m_acked = 0; exp_busy = 1;
            end
            4: begin
                if (!m_acked)   exp_reply = NR;
                else if (m_err) begin exp_reply = BE; ms = 0; end
                else            begin exp_reply = {1'b0, m_data[31:16]}; ms = 5; end
            end
            default: begin exp_reply = {1'b0, m_data[15:0]}; ms = 0; end
        endcase
    endtask

    // one 17-bit full-duplex frame, 4-clock serial phases
    task automatic xfer(input logic [16:0] w, input int gap, input string req);
        logic [16:0] got;
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk) sdi = w[i];
            repeat (3) @(negedge clk);
            got[i] = sdo;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        check(req, {15'd0, got}, {15'd0, exp_reply});
        model_step(w);
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_ack(input logic [31:0] d, input bit e);
        @(negedge clk);
        mem_rdata = d; mem_err = e; mem_ack = 1'b1;
        m_data = d; m_err = e; m_acked = 1;
        @(negedge clk);
        mem_ack = 1'b0;
        exp_busy = 0;
    endtask

    initial begin
        exp_reply = NR;
        repeat (5) @(negedge clk);
        check("R2", {31'd0, mem_req}, 32'd0);
        check("R2", {31'd0, sdo}, 32'd1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        xfer({1'b0, NOP}, 4, "R2");           // first reply is not-ready
        xfer({1'b0, RD}, 0, "R7");            // no-op answered with complete
        xfer(17'h0_1234, 0, "R3");            // R9: back-to-back frames
        xfer(17'h0_5678, 2, "R3");
        check("R3", {31'd0, mem_req}, 32'd1);
        check("R3", mem_addr, 32'h1234_5678);
        xfer(17'h0_AAAA, 0, "R3");            // reply to low address frame
        xfer(17'h0_5555, 0, "R4");
        do_ack(32'hCAFE_F00D, 0);
        check("R10", {31'd0, mem_req}, 32'd0);
        xfer(17'h0_0F0F, 0, "R4");
        xfer(17'h0_F0F0, 0, "R5");            // upper result half
        xfer({1'b0, RD}, 0, "R5");            // lower half rides with next command
        xfer(17'h0_DEAD, 0, "R3");
        xfer(17'h0_BEE0, 0, "R3");
        xfer(17'h0_0000, 0, "R3");
        do_ack(32'h1111_2222, 1);
        xfer(17'h0_3333, 0, "R4");
        xfer({1'b0, NOP}, 0, "R6");           // bus error status
        xfer(17'h0_7777, 0, "R6");            // no-op decoded: complete
        xfer(17'h0_1234, 0, "R8");            // illegal reply; frame discarded
        xfer({1'b0, NOP}, 0, "R8");           // skip frame reply not-ready
        check("R8", {31'd0, mem_req}, 32'd0);
        xfer({1'b1, RD}, 0, "R8");            // idle again: complete
        xfer({1'b0, NOP}, 0, "R8");           // flagged word: illegal
        xfer({1'b0, NOP}, 0, "R8");
        xfer({1'b0, RD}, 0, "R7");
        xfer(17'h0_00AB, 0, "R3");
        xfer(17'h0_CD00, 0, "R3");
        fork
            xfer(17'h0_0001, 0, "R3");        // ack lands mid-frame
            begin repeat (40) @(negedge clk); do_ack(32'h89AB_CDEF, 0); end
        join
        xfer(17'h0_0002, 0, "R5");
        xfer({1'b0, NOP}, 0, "R5");
        xfer({1'b0, NOP}, 0, "R7");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule